// File: doc/BRIEF.md
# Configurable Serial Port with Status Read

A full-duplex asynchronous serial port with a small register interface of three words. A setup word sets the bit period in clock cycles and the line format: 5 to 8 data bits, one or two stop bits, and one of five parity modes. A write to the transmit word starts a character on the line. A read of the transmit word reports whether that character is still being sent.

A read of the receive word gives one of two results. If a byte is waiting, the read returns that byte with every upper bit clear. Otherwise the upper bits return flags that explain why no byte is present: nothing received yet, the port was restarted, a stop bit was bad, or a parity check failed. A receive interrupt stays high while a byte is waiting, and only the read that takes the byte clears it. Software can therefore test one word for "byte or reason", with no separate status register.

Both directions use the same bit period. The receiver finds the falling edge of a start bit, waits half a bit period, and checks the start bit again at its middle. It then samples every later bit at its middle.

Top module: `serial_port_core`

## Requirements
- R1: Setup word (address 0) bits [23:0] hold the bit period in clock cycles. The setup word reads back the value last written to it. After reset it reads 705 with every format bit zero.
- R2: Setup word format fields: bits [25:24] select the data bit count (0 gives 8, 1 gives 7, 2 gives 6, 3 gives 5). Bit 26 selects the stop bits (0 gives one, 1 gives two). Bits [29:27] select parity (0 none, 1 odd, 2 even, 3 mark, 4 space, 5 to 7 none). With all format bits zero the line is 8 data bits, no parity, one stop bit.
- R3: A write to address 1 sends, on txd_o, a start bit at 0, the low data bits of bits [7:0] least significant bit first, the parity bit if one is enabled, and then the stop bits at 1. Each bit lasts one bit period. Odd parity makes the count of ones in data plus parity odd, and even parity makes it even. The line rests at 1.
- R4: A read of address 1 returns bit 8 set, with all other bits zero, from the write until the last stop bit ends. After that it returns zero. A write to address 1 while bit 8 is set is ignored and sends nothing.
- R5: The receiver detects a start bit on a falling edge. It checks the start bit again half a bit period later and drops a start pulse that has returned high by then. It samples each later bit one bit period apart, least significant bit first.
- R6: A read of address 2 while a byte is waiting returns the byte in bits [7:0] with bits [31:8] zero. For words shorter than 8 bits, the unused high data bits read as zero.
- R7: A read of address 2 with no byte waiting sets bit 8. It also sets bit 9 if a reset or a setup write has occurred since the last read of address 2, bit 10 if a received stop bit was 0, and bit 11 if a received parity bit was wrong. A character with either error is not delivered. Any read of address 2 clears bits 9 to 11.
- R8: rx_irq_o goes high when a good character arrives and stays high until a read of address 2 clears it.
- R9: A good character that arrives while a byte is still waiting replaces that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Word select: 0 setup, 1 transmit, 2 receive |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_rd_i | input | 1 | Read strobe, one cycle; takes the waiting byte at address 2 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected word, combinational |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line, asynchronous |
| rx_irq_o | output | 1 | High while a received byte is waiting |

## Verification
A wrong bit counter or a wrong frame length in the transmitter shows up within one character. The decoded data moves, the parity bit lands in a stop slot, or a frame starts that nobody asked for. A wrong sampling point or a wrong receive field decode shows up on the first read of the receive word after a character: the data is wrong, or an error or empty flag appears that should not. A bad interrupt or flag clear shows up in the cycle after a receive read, and the bench reads that word twice in a row to catch it.

// File: rtl/serial_pkg.sv
package serial_pkg;

  localparam logic [1:0] ADDR_SETUP = 2'd0;
  localparam logic [1:0] ADDR_TX    = 2'd1;
  localparam logic [1:0] ADDR_RX    = 2'd2;
  localparam int         FMT_W      = 6;
  localparam int         FRAME_W    = 12;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       two_stop;
    par_e       par;
  } line_fmt_t;

  function automatic line_fmt_t decode_fmt(logic [FMT_W-1:0] f);
    line_fmt_t r;
    r.nbits    = 4'd8 - {2'b00, f[1:0]};
    r.two_stop = f[2];
    case (f[5:3])
      3'd1:    r.par = PAR_ODD;
      3'd2:    r.par = PAR_EVEN;
      3'd3:    r.par = PAR_MARK;
      3'd4:    r.par = PAR_SPACE;
      default: r.par = PAR_NONE;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] word_mask(logic [3:0] nbits);
    logic [8:0] one;
    one = 9'd1 << nbits;
    return 8'(one - 9'd1);
  endfunction

  function automatic logic par_calc(par_e p, logic [7:0] d);
    case (p)
      PAR_ODD:  return ~^d;
      PAR_EVEN: return ^d;
      PAR_MARK: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sp_tx.sv
module sp_tx
  import serial_pkg::*;
#(
  parameter int DIV_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [7:0]       data_i,
  input  logic [DIV_W-1:0] div_i,
  input  line_fmt_t        fmt_i,
  output logic             txd_o,
  output logic             busy_o
);

  logic [FRAME_W-1:0] frame, sh_q;
  logic [3:0]         len, left_q;
  logic [DIV_W-1:0]   cnt_q, div_q;
  logic               busy_q;
  logic [7:0]         dmask;

  always_comb begin
    dmask = data_i & word_mask(fmt_i.nbits);
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(fmt_i.nbits)) frame[1+i] = dmask[i];
    end
    if (fmt_i.par != PAR_NONE) frame[4'd1 + fmt_i.nbits] = par_calc(fmt_i.par, dmask);
    len = 4'd1 + fmt_i.nbits + {3'b000, fmt_i.par != PAR_NONE}
        + (fmt_i.two_stop ? 4'd2 : 4'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
      div_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (load_i) begin
        sh_q   <= frame;
        left_q <= len;
        cnt_q  <= div_i - 1'b1;
        div_q  <= div_i;
        busy_q <= 1'b1;
      end
    end else if (cnt_q == '0) begin
      sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
      cnt_q <= div_q - 1'b1;
      if (left_q == 4'd1) begin
        busy_q <= 1'b0;
        sh_q   <= '1;
      end
      left_q <= left_q - 4'd1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign txd_o  = sh_q[0];
  assign busy_o = busy_q;

  a_r3_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> txd_o);
  a_r3_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !txd_o);
  a_r4_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (left_q != 4'd0 && left_q <= 4'(FRAME_W)));

endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import serial_pkg::*;
#(
  parameter int DIV_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxd_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  input  line_fmt_t        fmt_i,
  output logic             done_o,
  output logic [7:0]       data_o,
  output logic             ferr_o,
  output logic             perr_o
);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_st_e;

  rx_st_e           st_q;
  logic             s1_q, s2_q, s3_q;
  logic [DIV_W-1:0] cnt_q;
  logic [3:0]       idx_q;
  logic [7:0]       sh_q;
  logic             pbit_q, done_q, ferr_q;
  logic             fall, tick;

  assign fall = s3_q & ~s2_q;
  assign tick = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= rxd_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
      done_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (restart_i) begin
        st_q <= RX_IDLE;
      end else begin
        if (st_q != RX_IDLE) cnt_q <= tick ? div_i - 1'b1 : cnt_q - 1'b1;
        case (st_q)
          RX_IDLE: if (fall) begin
            st_q  <= RX_START;
            cnt_q <= div_i >> 1;
          end
          RX_START: if (tick) begin
            st_q  <= s2_q ? RX_IDLE : RX_DATA;
            idx_q <= '0;
          end
          RX_DATA: if (tick) begin
            sh_q  <= {s2_q, sh_q[7:1]};
            idx_q <= idx_q + 4'd1;
            if (idx_q == fmt_i.nbits - 4'd1)
              st_q <= (fmt_i.par != PAR_NONE) ? RX_PAR : RX_STOP;
          end
          RX_PAR: if (tick) begin
            pbit_q <= s2_q;
            st_q   <= RX_STOP;
          end
          RX_STOP: if (tick) begin
            done_q <= 1'b1;
            ferr_q <= ~s2_q;
            st_q   <= RX_IDLE;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign data_o = sh_q >> (4'd8 - fmt_i.nbits);
  assign done_o = done_q;
  assign ferr_o = ferr_q;
  assign perr_o = (fmt_i.par != PAR_NONE) && (pbit_q != par_calc(fmt_i.par, data_o));

  a_r5_bit_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == RX_DATA |-> idx_q < fmt_i.nbits);
  a_r5_done_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(st_q == RX_STOP));

endmodule

// File: rtl/serial_port_core.sv
module serial_port_core
  import serial_pkg::*;
#(
  parameter int DIV_W     = 24,
  parameter int RESET_DIV = 705
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  bus_addr_i,
  input  logic        bus_wr_i,
  input  logic        bus_rd_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        txd_o,
  input  logic        rxd_i,
  output logic        rx_irq_o
);

  localparam int FMT_LSB = DIV_W;

  logic [DIV_W-1:0] div_q;
  logic [FMT_W-1:0] fmt_q;
  line_fmt_t        fmt;
  logic             setup_wr, tx_wr, rx_rd;
  logic             tx_busy;
  logic             rx_done, rx_ferr, rx_perr;
  logic [7:0]       rx_byte;
  logic             valid_q, restart_q, ferr_q, perr_q;
  logic [7:0]       data_q;
  logic [31:0]      setup_rd;
  logic             unused_bits;

  assign unused_bits = ^bus_wdata_i[31:FMT_LSB+FMT_W];
  assign fmt      = decode_fmt(fmt_q);
  assign setup_wr = bus_wr_i && bus_addr_i == ADDR_SETUP;
  assign tx_wr    = bus_wr_i && bus_addr_i == ADDR_TX;
  assign rx_rd    = bus_rd_i && bus_addr_i == ADDR_RX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_W'(RESET_DIV);
      fmt_q <= '0;
    end else if (setup_wr) begin
      div_q <= bus_wdata_i[DIV_W-1:0];
      fmt_q <= bus_wdata_i[FMT_LSB +: FMT_W];
    end
  end

  sp_tx #(.DIV_W(DIV_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tx_wr),
    .data_i (bus_wdata_i[7:0]),
    .div_i  (div_q),
    .fmt_i  (fmt),
    .txd_o  (txd_o),
    .busy_o (tx_busy)
  );

  sp_rx #(.DIV_W(DIV_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rxd_i     (rxd_i),
    .restart_i (setup_wr),
    .div_i     (div_q),
    .fmt_i     (fmt),
    .done_o    (rx_done),
    .data_o    (rx_byte),
    .ferr_o    (rx_ferr),
    .perr_o    (rx_perr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      data_q    <= '0;
      restart_q <= 1'b1;
      ferr_q    <= 1'b0;
      perr_q    <= 1'b0;
    end else begin
      if (rx_rd) begin
        valid_q   <= 1'b0;
        restart_q <= 1'b0;
        ferr_q    <= 1'b0;
        perr_q    <= 1'b0;
      end
      if (setup_wr) restart_q <= 1'b1;
      if (rx_done) begin
        if (rx_ferr)      ferr_q <= 1'b1;
        if (rx_perr)      perr_q <= 1'b1;
        if (!rx_ferr && !rx_perr) begin
          valid_q <= 1'b1;
          data_q  <= rx_byte;
        end
      end
    end
  end

  always_comb begin
    setup_rd = '0;
    setup_rd[DIV_W-1:0] = div_q;
    setup_rd[FMT_LSB +: FMT_W] = fmt_q;
  end

  always_comb begin
    case (bus_addr_i)
      ADDR_SETUP: bus_rdata_o = setup_rd;
      ADDR_TX:    bus_rdata_o = {23'd0, tx_busy, 8'd0};
      ADDR_RX:    bus_rdata_o = valid_q ? {24'd0, data_q}
                                        : {20'd0, perr_q, ferr_q, restart_q, 1'b1, 8'd0};
      default:    bus_rdata_o = '0;
    endcase
  end

  assign rx_irq_o = valid_q;

  a_r8_irq_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_irq_o) |-> $past(rx_rd));
  a_r6_clean_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_RX && rx_irq_o) |-> bus_rdata_o[31:8] == 24'd0);
  a_r7_empty_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_RX && !rx_irq_o) |-> bus_rdata_o[8]);
  a_r4_busy_bit_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == ADDR_TX |-> $countones(bus_rdata_o) <= 1);

endmodule

// File: tb/serial_port_core_tb_top.sv
`timescale 1ns/1ps
module serial_port_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        txd;
  logic        rxd = 1'b1;
  logic        irq;

  int vectors = 0;
  int miscomp = 0;
  int div_c = 16, nb_c = 8, ts_c = 0, par_c = 0;
  int exp_tx[$];

  always #2.5 clk = ~clk;

  serial_port_core dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .txd_o       (txd),
    .rxd_i       (rxd),
    .rx_irq_o    (irq)
  );

  function automatic logic expp(int p, logic [7:0] d);
    case (p)
      1: return ~^d;
      2: return ^d;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] msk(int n);
    return 8'((1 << n) - 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  endtask

  task automatic bwr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic set_fmt(int d, int n, int ts, int p);
    logic [31:0] w, r;
    w = 32'(d);
    w[25:24] = 2'(8 - n);
    w[26] = ts[0];
    w[29:27] = 3'(p);
    bwr(2'd0, w);
    div_c = d; nb_c = n; ts_c = ts; par_c = p;
    brd(2'd0, r);
    chk("R1/R2 setup readback", r, w);
    brd(2'd2, r);
    chk("R7 restart flag after setup write", r, 32'h300);
  endtask

  task automatic txs(logic [7:0] b);
    exp_tx.push_back(int'(b & msk(nb_c)));
    bwr(2'd1, {24'd0, b});
  endtask

  task automatic tx_wait();
    logic [31:0] r;
    do brd(2'd1, r); while (r[8]);
    repeat (div_c) @(negedge clk);
  endtask

  task automatic rxf(logic [7:0] b, bit badp, bit bads);
    @(negedge clk);
    rxd = 1'b0;
    repeat (div_c) @(negedge clk);
    for (int i = 0; i < nb_c; i++) begin
      rxd = b[i];
      repeat (div_c) @(negedge clk);
    end
    if (par_c != 0) begin
      rxd = expp(par_c, b & msk(nb_c)) ^ badp;
      repeat (div_c) @(negedge clk);
    end
    for (int s = 0; s < (ts_c ? 2 : 1); s++) begin
      rxd = (s == 0) ? ~bads : 1'b1;
      repeat (div_c) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (div_c) @(negedge clk);
  endtask

  // monitor: decodes txd with the bench's view of the format, pops the scoreboard
  initial begin
    logic [7:0] d;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        repeat (div_c / 2) @(negedge clk);
        chk("R3 start bit", {31'd0, txd}, 32'd0);
        d = '0;
        for (int i = 0; i < nb_c; i++) begin
          repeat (div_c) @(negedge clk);
          d[i] = txd;
        end
        if (par_c != 0) begin
          repeat (div_c) @(negedge clk);
          chk("R3 parity bit", {31'd0, txd}, {31'd0, expp(par_c, d)});
        end
        for (int s = 0; s < (ts_c ? 2 : 1); s++) begin
          repeat (div_c) @(negedge clk);
          chk("R3 stop bit", {31'd0, txd}, 32'd1);
        end
        if (exp_tx.size() == 0) begin
          vectors++;
          miscomp++;
          $display("FAIL R4 unexpected frame: actual 0x%0h expected none", d);
        end else begin
          chk("R3 tx data", {24'd0, d}, 32'(exp_tx.pop_front()));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscomp++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 idle line high", {31'd0, txd}, 32'd1);
    chk("R8 irq low after reset", {31'd0, irq}, 32'd0);
    brd(2'd0, r);
    chk("R1 reset divisor, R2 zero format", r, 32'd705);
    brd(2'd2, r);
    chk("R7 empty and restart after reset", r, 32'h300);
    brd(2'd2, r);
    chk("R7 restart cleared by read", r, 32'h100);

    // 8N1
    set_fmt(16, 8, 0, 0);
    txs(8'h5A);
    brd(2'd1, r);
    chk("R4 busy while sending", r, 32'h100);
    bwr(2'd1, 32'h11);               // ignored: busy
    tx_wait();
    brd(2'd1, r);
    chk("R4 idle after frame", r, 32'h0);
    chk("R4 write while busy ignored", 32'(exp_tx.size()), 32'd0);

    rxf(8'hA5, 1'b0, 1'b0);
    chk("R8 irq high with byte", {31'd0, irq}, 32'd1);
    repeat (50) @(negedge clk);
    chk("R8 irq held until read", {31'd0, irq}, 32'd1);
    brd(2'd2, r);
    chk("R6 clean byte 8N1", r, 32'hA5);
    chk("R8 irq cleared by read", {31'd0, irq}, 32'd0);
    brd(2'd2, r);
    chk("R7 empty after take", r, 32'h100);

    // R9 overwrite
    rxf(8'h11, 1'b0, 1'b0);
    rxf(8'h22, 1'b0, 1'b0);
    brd(2'd2, r);
    chk("R9 newest byte kept", r, 32'h22);

    // R5 short start pulse rejected
    @(negedge clk);
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    chk("R5 glitch no irq", {31'd0, irq}, 32'd0);
    brd(2'd2, r);
    chk("R5 glitch no byte", r, 32'h100);

    // 7 bits, even parity
    set_fmt(16, 7, 0, 2);
    txs(8'hB5);
    tx_wait();
    rxf(8'h35, 1'b0, 1'b0);
    brd(2'd2, r);
    chk("R2/R6 7E1 receive", r, 32'h35);
    rxf(8'h35, 1'b1, 1'b0);
    chk("R7 parity error no irq", {31'd0, irq}, 32'd0);
    brd(2'd2, r);
    chk("R7 parity error flag", r, 32'h900);
    brd(2'd2, r);
    chk("R7 error cleared by read", r, 32'h100);

    // 5 bits, odd parity, two stop bits
    set_fmt(16, 5, 1, 1);
    txs(8'hF3);
    tx_wait();
    rxf(8'h0B, 1'b0, 1'b0);
    brd(2'd2, r);
    chk("R6 5-bit word upper zero", r, 32'h0B);

    // 8 bits, mark parity, framing error
    set_fmt(16, 8, 0, 3);
    txs(8'h81);
    tx_wait();
    rxf(8'h42, 1'b0, 1'b0);
    brd(2'd2, r);
    chk("R2 mark parity receive", r, 32'h42);
    rxf(8'h42, 1'b0, 1'b1);
    brd(2'd2, r);
    chk("R7 framing error flag", r, 32'h500);

    // 6 bits, space parity
    set_fmt(16, 6, 0, 4);
    txs(8'h2A);
    tx_wait();
    rxf(8'h15, 1'b0, 1'b0);
    brd(2'd2, r);
    chk("R2 space parity receive", r, 32'h15);

    repeat (40) @(negedge clk);
    chk("R3 all frames seen", 32'(exp_tx.size()), 32'd0);
    summary();
  end

endmodule